// File: doc/BRIEF.md
# Two-Level Daisy-Chain Bus Arbiter

This block decides which device gets the bus. The devices sit on two priority levels, upper and lower. Each level has a request line, which is the OR of the request bits of every device on that level. Each level also has a grant path that runs through its devices in a fixed order. When the bus is idle, the arbiter sends a grant into the chain of the highest level that has a request pending. The first device on that chain that is asking for the bus keeps the grant. Each device ahead of it that is not asking passes the grant on to the next one. Device index 0 is the stage nearest the arbiter.

Once a device is chosen, that device owns the bus and keeps it for as long as its request stays high. No other request can take the bus away from the owner, on either level. When the owner drops its request, all grants clear on the next clock edge. The arbiter then spends one idle cycle before it makes a new decision. The control logic is a three-state machine:
- `ST_IDLE` means no owner.
- `ST_OWN_HI` means an upper-level device owns the bus.
- `ST_OWN_LO` means a lower-level device owns the bus.

The transitions are:
- `IDLE→OWN_HI`: taken when any upper request is present.
- `IDLE→OWN_LO`: taken when only lower requests are present.
- `OWN_HI→IDLE` and `OWN_LO→IDLE`: taken when the owner's request is low.

Top module: `arb2_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every device grant and both level grant lines are low.
- R2: A level counts as requesting when any one or more of its device request bits is 1, regardless of which bit it is.
- R3: In ST_IDLE, if any upper-level request bit is 1 at a clock edge, an upper-level device holds the grant after that edge, even when lower-level requests are also present.
- R4: A lower-level device is granted only from ST_IDLE, and only when no upper-level request bit is 1 at that edge.
- R5: Within the chosen level, the device that receives the grant is the requesting device with the lowest index (bit 0 is nearest the arbiter). Non-requesting devices of lower index pass the grant on.
- R6: While the owning device keeps its request bit at 1, its grant stays unchanged and no other grant bit rises.
- R7: At the first edge at which the owner's request bit is 0, every grant falls. The next decision is taken one edge later, which leaves exactly one idle cycle.
- R8: At most one grant bit across both levels is 1 in any cycle.
- R9: `lvl_gnt_hi` is 1 exactly when one of the `gnt_hi` bits is 1. `lvl_gnt_lo` is 1 exactly when one of the `gnt_lo` bits is 1.
- R10: While the bus is owned, requests from other devices (nearer ones and upper-level ones included) have no effect on any output until the owner releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_hi | input | N_DEV | Request bits of the upper-level devices, bit 0 nearest the arbiter |
| req_lo | input | N_DEV | Request bits of the lower-level devices, bit 0 nearest the arbiter |
| gnt_hi | output | N_DEV | Grant held by each upper-level device |
| gnt_lo | output | N_DEV | Grant held by each lower-level device |
| lvl_gnt_hi | output | 1 | Upper level grant line is active |
| lvl_gnt_lo | output | 1 | Lower level grant line is active |

## Verification
The state register and the owner register each drive the outputs directly, so a fault in either one shows at the ports in the cycle it occurs. A wrong state shows as a level grant line that disagrees with the device grants. A wrong owner register shows as a grant on a device that was not the nearest requester, or as two grant bits high at once. If the release path misses the owner's request drop, the grant stays high one edge too long. If it takes the new decision too early, the idle cycle disappears. Both faults are visible within one cycle of the release.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OWN_HI = 2'd1,
        ST_OWN_LO = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb2_stage.sv
// One position on a grant chain: keeps the grant when requesting,
// otherwise forwards it downstream.
module arb2_stage (
    input  logic grant_in,
    input  logic dev_req,
    output logic take,
    output logic grant_out
);

    assign take      = grant_in &  dev_req;
    assign grant_out = grant_in & ~dev_req;

endmodule

// File: rtl/arb2_chain.sv
// A level: the wired-OR request line plus the grant chain through its devices.
module arb2_chain #(
    parameter int N_DEV = 4
) (
    input  logic             chain_en,
    input  logic [N_DEV-1:0] dev_req,
    output logic             level_req,
    output logic [N_DEV-1:0] take
);

    logic [N_DEV-1:0] pass;

    assign level_req = |dev_req;
    assign pass[0]   = chain_en;

    for (genvar i = 0; i < N_DEV; i++) begin : g_pos
        if (i < N_DEV - 1) begin : g_mid
            arb2_stage u_stage (
                .grant_in (pass[i]),
                .dev_req  (dev_req[i]),
                .take     (take[i]),
                .grant_out(pass[i+1])
            );
        end else begin : g_last
            // The last device has nowhere to forward an unclaimed grant.
            assign take[i] = pass[i] & dev_req[i];
        end
    end

endmodule

// File: rtl/arb2_ctrl.sv
// Ownership state machine: decides only from idle, holds until release.
module arb2_ctrl
    import arb2_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] req_hi,
    input  logic [N_DEV-1:0] req_lo,
    input  logic             line_hi,
    input  logic             line_lo,
    input  logic [N_DEV-1:0] take_hi,
    input  logic [N_DEV-1:0] take_lo,
    output logic             en_hi,
    output logic             en_lo,
    output logic [N_DEV-1:0] owner_hi,
    output logic [N_DEV-1:0] owner_lo,
    output logic             lvl_hi,
    output logic             lvl_lo
);

    arb_state_e state_q, state_d;
    logic       keep_hi, keep_lo;

    assign keep_hi = |(owner_hi & req_hi);
    assign keep_lo = |(owner_lo & req_lo);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (line_hi)      state_d = ST_OWN_HI;
                else if (line_lo) state_d = ST_OWN_LO;
            end
            ST_OWN_HI: if (!keep_hi) state_d = ST_IDLE;
            ST_OWN_LO: if (!keep_lo) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Owner register: loaded on a decision, cleared on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_hi <= '0;
            owner_lo <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    owner_hi <= take_hi;
                    owner_lo <= take_lo;
                end
                ST_OWN_HI: if (!keep_hi) owner_hi <= '0;
                ST_OWN_LO: if (!keep_lo) owner_lo <= '0;
                default: begin
                    owner_hi <= '0;
                    owner_lo <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        en_hi  = 1'b0;
        en_lo  = 1'b0;
        lvl_hi = 1'b0;
        lvl_lo = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                en_hi = line_hi;
                en_lo = line_lo & ~line_hi;
            end
            ST_OWN_HI: lvl_hi = 1'b1;
            ST_OWN_LO: lvl_lo = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/arb2_top.sv
module arb2_top #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] req_hi,
    input  logic [N_DEV-1:0] req_lo,
    output logic [N_DEV-1:0] gnt_hi,
    output logic [N_DEV-1:0] gnt_lo,
    output logic             lvl_gnt_hi,
    output logic             lvl_gnt_lo
);

    logic             line_hi, line_lo;
    logic             en_hi, en_lo;
    logic [N_DEV-1:0] take_hi, take_lo;

    arb2_chain #(.N_DEV(N_DEV)) u_chain_hi (
        .chain_en (en_hi),
        .dev_req  (req_hi),
        .level_req(line_hi),
        .take     (take_hi)
    );

    arb2_chain #(.N_DEV(N_DEV)) u_chain_lo (
        .chain_en (en_lo),
        .dev_req  (req_lo),
        .level_req(line_lo),
        .take     (take_lo)
    );

    arb2_ctrl #(.N_DEV(N_DEV)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_hi  (req_hi),
        .req_lo  (req_lo),
        .line_hi (line_hi),
        .line_lo (line_lo),
        .take_hi (take_hi),
        .take_lo (take_lo),
        .en_hi   (en_hi),
        .en_lo   (en_lo),
        .owner_hi(gnt_hi),
        .owner_lo(gnt_lo),
        .lvl_hi  (lvl_gnt_hi),
        .lvl_lo  (lvl_gnt_lo)
    );

endmodule

// File: rtl/arb2_checker.sv
module arb2_checker #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEV-1:0] req_hi,
    input logic [N_DEV-1:0] req_lo,
    input logic [N_DEV-1:0] gnt_hi,
    input logic [N_DEV-1:0] gnt_lo,
    input logic             lvl_gnt_hi,
    input logic             lvl_gnt_lo
);

    logic idle;
    assign idle = (gnt_hi == '0) && (gnt_lo == '0);

    // R8
    a_r8_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_hi, gnt_lo}));

    // R3
    a_r3_upper_first: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (req_hi != '0)) |=> (gnt_hi != '0) && (gnt_lo == '0));

    // R4
    a_r4_lower_only_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (req_hi == '0) && (req_lo != '0)) |=> (gnt_lo != '0));

    // R5
    a_r5_nearest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (req_hi != '0)) |=> gnt_hi == ($past(req_hi) & (~$past(req_hi) + 1'b1)));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_hi & req_hi) != '0) |=> $stable(gnt_hi) && (gnt_lo == '0));

    // R7
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_lo != '0) && ((gnt_lo & req_lo) == '0)) |=> idle);

    // R9
    a_r9_level_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_gnt_hi == (gnt_hi != '0)) && (lvl_gnt_lo == (gnt_lo != '0)));

endmodule

bind arb2_top arb2_checker #(.N_DEV(N_DEV)) u_arb2_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_hi    (req_hi),
    .req_lo    (req_lo),
    .gnt_hi    (gnt_hi),
    .gnt_lo    (gnt_lo),
    .lvl_gnt_hi(lvl_gnt_hi),
    .lvl_gnt_lo(lvl_gnt_lo)
);

// File: tb/sim_arb2_top.sv
module sim_arb2_top;

    localparam int N = 4;

    typedef struct {
        logic [N-1:0] gh;
        logic [N-1:0] gl;
        logic         lh;
        logic         ll;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_hi = '0;
    logic [N-1:0] req_lo = '0;
    logic [N-1:0] gnt_hi, gnt_lo;
    logic         lvl_gnt_hi, lvl_gnt_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    // model of the expected ownership
    int           m_st = 0;   // 0 idle, 1 upper owns, 2 lower owns
    logic [N-1:0] m_hi = '0;
    logic [N-1:0] m_lo = '0;

    always #4 clk = ~clk;

    arb2_top #(.N_DEV(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
        .gnt_hi(gnt_hi), .gnt_lo(gnt_lo),
        .lvl_gnt_hi(lvl_gnt_hi), .lvl_gnt_lo(lvl_gnt_lo)
    );

    function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    // Driver: apply requests for one edge and push the expected result.
    task automatic step(input logic [N-1:0] h, input logic [N-1:0] l, input string tag);
        exp_t e;
        @(negedge clk);
        req_hi = h;
        req_lo = l;
        case (m_st)
            0: begin
                if (h != '0)      begin m_st = 1; m_hi = lowest(h); end
                else if (l != '0) begin m_st = 2; m_lo = lowest(l); end
            end
            1: if ((m_hi & h) == '0) begin m_st = 0; m_hi = '0; end
            default: if ((m_lo & l) == '0) begin m_st = 0; m_lo = '0; end
        endcase
        e.gh = m_hi; e.gl = m_lo; e.lh = (m_st == 1); e.ll = (m_st == 2); e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compare shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (gnt_hi !== e.gh || gnt_lo !== e.gl || lvl_gnt_hi !== e.lh || lvl_gnt_lo !== e.ll) begin
                fails++;
                $display("FAIL %s: got hi=%b lo=%b lh=%b ll=%b, expected hi=%b lo=%b lh=%b ll=%b",
                         e.tag, gnt_hi, gnt_lo, lvl_gnt_hi, lvl_gnt_lo, e.gh, e.gl, e.lh, e.ll);
            end
            if (!$onehot0({gnt_hi, gnt_lo})) begin
                fails++;
                $display("FAIL R8: got grants %b, expected at most one bit", {gnt_hi, gnt_lo});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;  // R1 during reset
        if (gnt_hi !== '0 || gnt_lo !== '0 || lvl_gnt_hi || lvl_gnt_lo) begin
            fails++;
            $display("FAIL R1: got hi=%b lo=%b, expected 0000 0000", gnt_hi, gnt_lo);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0000, 4'b0000, "R1 idle after reset");
        step(4'b0000, 4'b0100, "R4 R2 lower granted alone");
        step(4'b0001, 4'b0101, "R6 R10 upper does not preempt");
        step(4'b0011, 4'b0100, "R10 hold vs new requests");
        step(4'b0011, 4'b0000, "R7 release drops grants");
        step(4'b0011, 4'b0000, "R3 R5 upper nearest after idle");
        step(4'b0010, 4'b0000, "R7 owner bit0 released");
        step(4'b1010, 4'b1111, "R3 R5 bit1 wins over lower");
        step(4'b1010, 4'b1111, "R6 stable grant");
        step(4'b1000, 4'b1111, "R7 release with others waiting");
        step(4'b1000, 4'b1111, "R5 R9 farthest device");
        step(4'b0000, 4'b1000, "R7 release before lower");
        step(4'b0000, 4'b1000, "R4 R2 lower bit3");
        step(4'b0000, 4'b1001, "R10 nearer lower ignored");
        step(4'b0000, 4'b0001, "R7 lower release");
        step(4'b0000, 4'b0001, "R5 lower bit0");
        step(4'b0000, 4'b0000, "R7 final release");
        step(4'b0000, 4'b0000, "R9 lines idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected end of test");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule